// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a bank of eight binary lock flags that two independent agents, a left port and a right port, use to agree on who may use a shared resource. The flags live apart from any data storage. Each port writes a single bit to a flag chosen by a three-bit index. Writing zero asks for the lock and writing one gives it up. A flag reads active low: the side that holds the lock sees zero and every other reader sees one.

When one side asks for a lock that the other side already holds, the request is not lost. It is kept in that side's own request latch and takes effect the moment the holder lets go, so ownership passes straight across without the lock ever reading free. Each read is captured when the port's select and output enable both become active. The captured value is then held until one of them drops, so a polling loop has to toggle one of these signals between polls. All state is synchronous to one clock, and an active-low reset clears it.

Top module: `dual_sema_bank`

## Requirements
- R1: After reset all eight flags are free, no requests are pending, and both read outputs are 16'hFFFF.
- R2: The index selects exactly one of eight flags. A write or read on one index leaves every other flag unchanged.
- R3: A zero written to a free flag makes the writer its owner. In the next read the owner sees 16'h0000 and the other side sees 16'hFFFF.
- R4: A zero written by the non-owner is stored as pending. It changes neither side's read value.
- R5: When the owner writes one while the other side has a request pending, the other side becomes the owner in that same clock and the flag never reads free.
- R6: When the owner writes one with nothing pending, the flag becomes free. A non-owner writing one withdraws its pending request, so a later release frees the flag.
- R7: Zeros written by both sides to the same free flag in the same clock give the lock to the left side. The right request stays pending.
- R8: The read value is captured in the clock where select and output enable both become active. It holds until either of them goes inactive, even if the flag changes meanwhile.
- R9: A write takes effect only when that port's select and write strobe are both high. Otherwise it has no effect.
- R10: The one-bit flag value is copied to all 16 bits of the read output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_idx | input | 3 | Left flag index |
| l_wbit | input | 1 | Left write bit (0 request, 1 release) |
| l_rdata | output | 16 | Left captured read value |
| r_sel | input | 1 | Right semaphore select |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_idx | input | 3 | Right flag index |
| r_wbit | input | 1 | Right write bit (0 request, 1 release) |
| r_rdata | output | 16 | Right captured read value |

## Verification
Two things can happen to the same flag in one clock: both sides can request it, and one side can release it while the other side requests it. Directed steps provoke both cases by driving the two ports onto one index in a single cycle. The results are judged against the left-first priority and the direct hand-over. A read held active across a write from the other side checks that capture and ownership change do not interfere. A long random phase over a small index range creates many more such collisions, and the outputs are compared with the behavioural model on every clock.

// File: rtl/dual_sema_bank.sv
module dual_sema_bank #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);

  logic [N_SEM-1:0] req_l, req_r, own_l, own_r;
  logic [N_SEM-1:0] req_l_n, req_r_n, own_l_n, own_r_n;
  logic act_l, act_r, cap_l, cap_r;

  wire wr_l = l_sel & l_we;
  wire wr_r = r_sel & r_we;
  wire rd_l = l_sel & l_oe;
  wire rd_r = r_sel & r_oe;

  always_comb begin
    for (int i = 0; i < N_SEM; i++) begin
      req_l_n[i] = (wr_l && l_idx == IDX_W'(i)) ? ~l_wbit : req_l[i];
      req_r_n[i] = (wr_r && r_idx == IDX_W'(i)) ? ~r_wbit : req_r[i];
      own_l_n[i] = req_l_n[i] & ~(own_r[i] & req_r_n[i]);
      own_r_n[i] = req_r_n[i] & ~own_l_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_l <= '0;
      req_r <= '0;
      own_l <= '0;
      own_r <= '0;
      act_l <= 1'b0;
      act_r <= 1'b0;
      cap_l <= 1'b1;
      cap_r <= 1'b1;
    end else begin
      req_l <= req_l_n;
      req_r <= req_r_n;
      own_l <= own_l_n;
      own_r <= own_r_n;
      act_l <= rd_l;
      act_r <= rd_r;
      if (rd_l && !act_l) cap_l <= ~own_l[l_idx];
      if (rd_r && !act_r) cap_r <= ~own_r[r_idx];
    end
  end

  assign l_rdata = {DATA_W{cap_l}};
  assign r_rdata = {DATA_W{cap_r}};

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R4
  left_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(own_l) & ~own_l)) |-> $past(wr_l && l_wbit));

  // R4
  right_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(own_r) & ~own_r)) |-> $past(wr_r && r_wbit));

  // R7
  left_wins_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_l && !l_wbit && wr_r && !r_wbit && l_idx == r_idx &&
     !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

  // R8
  left_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_l && act_l) |=> $stable(l_rdata));

  // R8
  right_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_r && act_r) |=> $stable(r_rdata));

endmodule

// File: tb/test_dual_sema_bank.sv
module test_dual_sema_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_we = 0, l_oe = 0, l_wbit = 1;
  logic r_sel = 0, r_we = 0, r_oe = 0, r_wbit = 1;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic [15:0] l_rdata, r_rdata;

  always #4 clk = ~clk;

  dual_sema_bank i_dual_sema_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
  );

  int checks = 0, failures = 0;
  int m_reql[8], m_reqr[8], m_owner[8];
  bit m_capl = 1, m_capr = 1, m_actl = 0, m_actr = 0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (l_sel && l_oe && !m_actl) m_capl = (m_owner[l_idx] != 1);
    if (r_sel && r_oe && !m_actr) m_capr = (m_owner[r_idx] != 2);
    m_actl = l_sel && l_oe;
    m_actr = r_sel && r_oe;
    if (l_sel && l_we) m_reql[l_idx] = !l_wbit;
    if (r_sel && r_we) m_reqr[r_idx] = !r_wbit;
    for (int i = 0; i < 8; i++) begin
      if (m_owner[i] == 1 && m_reql[i] != 0) m_owner[i] = 1;
      else if (m_owner[i] == 2 && m_reqr[i] != 0) m_owner[i] = 2;
      else if (m_reql[i] != 0) m_owner[i] = 1;
      else if (m_reqr[i] != 0) m_owner[i] = 2;
      else m_owner[i] = 0;
    end
  endtask

  task automatic cyc(string tag,
                     bit ls, bit lw, bit lo, int li, bit ld,
                     bit rs, bit rw, bit ro, int ri, bit rd);
    l_sel = ls; l_we = lw; l_oe = lo; l_idx = 3'(li); l_wbit = ld;
    r_sel = rs; r_we = rw; r_oe = ro; r_idx = 3'(ri); r_wbit = rd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "l_rdata vs model", l_rdata, {16{m_capl}});
    chk(tag, "r_rdata vs model", r_rdata, {16{m_capr}});
  endtask

  task automatic idle(string tag);
    cyc(tag, 0,0,0,0,1, 0,0,0,0,1);
  endtask
  task automatic wl(string tag, int i, bit d);
    cyc(tag, 1,1,0,i,d, 0,0,0,0,1); idle(tag);
  endtask
  task automatic wr(string tag, int i, bit d);
    cyc(tag, 0,0,0,0,1, 1,1,0,i,d); idle(tag);
  endtask
  task automatic rl(string tag, int i, logic [15:0] exp);
    cyc(tag, 1,0,1,i,1, 0,0,0,0,1);
    chk(tag, "left read", l_rdata, exp);
    idle(tag);
  endtask
  task automatic rr(string tag, int i, logic [15:0] exp);
    cyc(tag, 0,0,0,0,1, 1,0,1,i,1);
    chk(tag, "right read", r_rdata, exp);
    idle(tag);
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_reql[i] = 0; m_reqr[i] = 0; m_owner[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1
    chk("R1", "left after reset", l_rdata, 16'hFFFF);
    chk("R1", "right after reset", r_rdata, 16'hFFFF);
    rl("R1", 0, 16'hFFFF);
    rr("R1", 6, 16'hFFFF);

    // R3 R10
    wl("R3", 2, 0);
    rl("R3", 2, 16'h0000);
    rr("R3", 2, 16'hFFFF);
    // R2
    rl("R2", 3, 16'hFFFF);
    rl("R2", 1, 16'hFFFF);

    // R4
    wr("R4", 2, 0);
    rr("R4", 2, 16'hFFFF);
    rl("R4", 2, 16'h0000);

    // R5
    wl("R5", 2, 1);
    rr("R5", 2, 16'h0000);
    rl("R5", 2, 16'hFFFF);

    // R6
    wr("R6", 2, 1);
    rl("R6", 2, 16'hFFFF);
    rr("R6", 2, 16'hFFFF);
    wl("R6", 5, 0);
    wr("R6", 5, 0);
    wr("R6", 5, 1);
    wl("R6", 5, 1);
    rr("R6", 5, 16'hFFFF);
    rl("R6", 5, 16'hFFFF);

    // R7
    cyc("R7", 1,1,0,7,0, 1,1,0,7,0); idle("R7");
    rl("R7", 7, 16'h0000);
    rr("R7", 7, 16'hFFFF);
    wl("R7", 7, 1);
    rr("R7", 7, 16'h0000);
    wr("R7", 7, 1);

    // R5 release and request in the same clock
    wl("R5", 6, 0);
    cyc("R5", 1,1,0,6,1, 1,1,0,6,0); idle("R5");
    rr("R5", 6, 16'h0000);
    wr("R5", 6, 1);

    // R9
    cyc("R9", 0,1,0,1,0, 1,0,0,1,0); idle("R9");
    rl("R9", 1, 16'hFFFF);
    rr("R9", 1, 16'hFFFF);
    cyc("R9", 1,0,1,1,0, 0,0,0,0,1); idle("R9");
    rl("R9", 1, 16'hFFFF);

    // R8
    cyc("R8", 1,0,1,4,1, 0,0,0,0,1);
    chk("R8", "capture free", l_rdata, 16'hFFFF);
    cyc("R8", 1,0,1,4,1, 1,1,0,4,0);
    cyc("R8", 1,0,1,4,1, 0,0,0,0,1);
    chk("R8", "held during change", l_rdata, 16'hFFFF);
    cyc("R8", 1,0,1,4,1, 0,0,0,0,1);
    chk("R8", "still held", l_rdata, 16'hFFFF);
    cyc("R8", 1,0,0,4,1, 0,0,0,0,1);
    cyc("R8", 1,0,1,4,1, 0,0,0,0,1);
    chk("R8", "recapture", l_rdata, 16'hFFFF);
    idle("R8");
    rr("R8", 4, 16'h0000);
    wr("R8", 4, 1);

    // R2 R3 R4 R5 R6 R7 R8 R9 R10 random collisions
    for (int n = 0; n < 3000; n++) begin
      cyc("R10", 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0,2)), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0,2)), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule